// File: doc/BRIEF.md
# Paged Receive Ring with Overflow Abort

This block accepts received packets as a byte stream and stores them in a circular ring of fixed-size pages held in an internal memory. The host sets the first page and the limit page of the ring, and a boundary page that marks the oldest page it has not yet consumed. A current-page register gives the page where the next packet will begin. Each packet starts at offset zero of that page and fills the pages that follow. When the packet ends cleanly, the current page moves past its last byte.

If any byte of a packet would land in the boundary page, the block drops that packet. The current page keeps the value it had when the packet began, so stored packets are never overwritten. The block sets a sticky overflow status bit and suspends reception. Freeing space by moving the boundary does not restart the ring. The host must clear the suspension by asserting and then releasing the halt command. While halt is asserted, stream bytes are ignored and the write position is held.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the control register reads 1 (halt asserted), first page reads 0, limit page reads NUM_PAGES, boundary reads NUM_PAGES-1, current page reads 0, status reads 0 and `irq` is low.
- R2: Packet byte i is stored at memory index current_page*PAGE_BYTES + i. When a page's last offset is filled, storage continues at offset 0 of the next ring page.
- R3: When a packet ends (`rx_last` on an accepted byte) without a boundary hit, the current page becomes the ring page after the page of its last byte. Status bit 0 (done) is set and `irq` goes high.
- R4: Page succession wraps: the page after (limit-1) is the first page.
- R5: A byte that would be written into the boundary page is not written and aborts the packet. The current page keeps its value from before the packet. Status bit 1 (overflow) is set. The remaining bytes up to `rx_last` are discarded.
- R6: Packets stored before an overflow keep their contents.
- R7: After an overflow, new packets are ignored, even if the boundary is moved, until the control register bit 0 has been written to 1 and back to 0.
- R8: Status bits are sticky. Writing a 1 to a status bit position clears that bit, and writing 0 leaves it unchanged. `irq` is the OR of the status bits.
- R9: While control bit 0 (halt) is 1, stream bytes are ignored and a packet in progress continues from where it stopped once halt is released.
- R10: Register map on `reg_addr`: 0 control, 1 first page, 2 limit page, 3 boundary page, 4 current page (host writable), 5 status. All registers read back on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Stream byte present |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the final byte of its packet |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Any status bit set |
| mem_raddr | input | MW (11) | Ring memory read index |
| mem_rdata | output | 8 | Ring memory read data |

## Verification
The hardest state to reach is an abort in the middle of a packet after the ring has already wrapped. The current page must first have gone past the limit and back to the first page, and the boundary must sit just ahead of it. The stimulus fills the ring with a packet that spans pages and with a packet interrupted by halt. It then moves the boundary and sends a packet that crosses the wrap. Finally it sends a long packet that runs into the boundary page partway through. The bench then checks that earlier packets are intact, that the current page was not changed, and that the suspension survives a boundary move until a halt cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_t;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_FIRST = 3'd1;
   localparam logic [2:0] RA_LIMIT = 3'd2;
   localparam logic [2:0] RA_BOUND = 3'd3;
   localparam logic [2:0] RA_CURR  = 3'd4;
   localparam logic [2:0] RA_STAT  = 3'd5;

   localparam int ST_DONE = 0;
   localparam int ST_OVF  = 1;
endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
   parameter int MW     = 11,
   parameter bit REG_RD = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [MW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [MW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << MW;

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   generate
      if (REG_RD) begin : g_rd_reg
         logic [7:0] rq;
         always_ff @(posedge clk) rq <= store[raddr];
         assign rdata = rq;
      end else begin : g_rd_comb
         assign rdata = store[raddr];
      end
   endgenerate
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int PGW       = 4,
   parameter int RST_LIMIT = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [2:0]     addr,
   input  logic [7:0]     wdata,
   output logic [7:0]     rdata,
   input  logic           pkt_done,
   input  logic [PGW-1:0] done_page,
   input  logic           abort,
   output logic           halt,
   output logic           lock,
   output logic [PGW-1:0] first_pg,
   output logic [PGW-1:0] limit_pg,
   output logic [PGW-1:0] bound_pg,
   output logic [PGW-1:0] curr_pg,
   output logic           irq
);
   localparam int PAD = 8 - PGW;

   logic [1:0] stat;
   logic [1:0] w1c;
   logic       unused_wbits;

   assign unused_wbits = ^wdata[7:PGW];
   assign w1c = (wr && addr == RA_STAT) ? wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt     <= 1'b1;
         first_pg <= '0;
         limit_pg <= PGW'(RST_LIMIT);
         bound_pg <= PGW'(RST_LIMIT - 1);
         curr_pg  <= '0;
         stat     <= '0;
         lock     <= 1'b0;
      end else begin
         if (wr && addr == RA_CTRL)  halt     <= wdata[0];
         if (wr && addr == RA_FIRST) first_pg <= wdata[PGW-1:0];
         if (wr && addr == RA_LIMIT) limit_pg <= wdata[PGW-1:0];
         if (wr && addr == RA_BOUND) bound_pg <= wdata[PGW-1:0];
         if (wr && addr == RA_CURR)  curr_pg  <= wdata[PGW-1:0];
         else if (pkt_done)          curr_pg  <= done_page;
         stat <= (stat & ~w1c) | {abort, pkt_done};
         if (abort)     lock <= 1'b1;
         else if (halt) lock <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         RA_CTRL:  rdata = {7'd0, halt};
         RA_FIRST: rdata = {{PAD{1'b0}}, first_pg};
         RA_LIMIT: rdata = {{PAD{1'b0}}, limit_pg};
         RA_BOUND: rdata = {{PAD{1'b0}}, bound_pg};
         RA_CURR:  rdata = {{PAD{1'b0}}, curr_pg};
         RA_STAT:  rdata = {6'd0, stat};
         default:  rdata = 8'h00;
      endcase
   end

   assign irq = |stat;

   // R3
   curr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_done && !(wr && addr == RA_CURR)) |=> $stable(curr_pg));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[ST_OVF] && !w1c[ST_OVF]) |=> stat[ST_OVF]);
endmodule

// File: rtl/rxr_wrctl.sv
module rxr_wrctl
   import rxr_pkg::*;
#(
   parameter int PGW  = 4,
   parameter int OFFW = 8,
   parameter int MW   = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rx_valid,
   input  logic [7:0]     rx_data,
   input  logic           rx_last,
   input  logic           halt,
   input  logic           lock,
   input  logic [PGW-1:0] first_pg,
   input  logic [PGW-1:0] limit_pg,
   input  logic [PGW-1:0] bound_pg,
   input  logic [PGW-1:0] curr_pg,
   output logic           mem_we,
   output logic [MW-1:0]  mem_waddr,
   output logic [7:0]     mem_wdata,
   output logic           pkt_done,
   output logic [PGW-1:0] done_page,
   output logic           abort
);
   rx_state_t       state;
   logic [PGW-1:0]  fill_pg, tgt_pg;
   logic [OFFW-1:0] fill_off, tgt_off;
   logic            take, hit, live;

   function automatic logic [PGW-1:0] ring_next(input logic [PGW-1:0] p,
                                                input logic [PGW-1:0] f,
                                                input logic [PGW-1:0] l);
      logic [PGW-1:0] q;
      q = p + 1'b1;
      return (q == l) ? f : q;
   endfunction

   assign take      = rx_valid && !halt;
   assign tgt_pg    = (state == RX_IDLE) ? curr_pg : fill_pg;
   assign tgt_off   = (state == RX_IDLE) ? '0 : fill_off;
   assign hit       = (tgt_pg == bound_pg);
   assign live      = take && ((state == RX_IDLE && !lock) || state == RX_FILL);
   assign mem_waddr = {tgt_pg[PGW-2:0], tgt_off};
   assign mem_wdata = rx_data;
   assign done_page = ring_next(tgt_pg, first_pg, limit_pg);
   assign mem_we    = live && !hit;
   assign abort     = live && hit;
   assign pkt_done  = live && !hit && rx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         fill_pg  <= '0;
         fill_off <= '0;
      end else if (live) begin
         if (hit) begin
            state <= rx_last ? RX_IDLE : RX_DROP;
         end else if (rx_last) begin
            state <= RX_IDLE;
         end else begin
            state <= RX_FILL;
            if (&tgt_off) begin
               fill_pg  <= ring_next(tgt_pg, first_pg, limit_pg);
               fill_off <= '0;
            end else begin
               fill_pg  <= tgt_pg;
               fill_off <= tgt_off + 1'b1;
            end
         end
      end else if (state == RX_DROP && take && rx_last) begin
         state <= RX_IDLE;
      end
   end

   // R5
   no_bound_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_waddr[MW-1:OFFW] != bound_pg[PGW-2:0]) || (tgt_pg != bound_pg));
   // R5
   abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> !mem_we && !pkt_done);
   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(fill_pg) && $stable(fill_off) && $stable(state));
   // R7
   lock_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && lock) |-> !mem_we && !pkt_done);
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
   import rxr_pkg::*;
#(
   parameter int NUM_PAGES     = 8,
   parameter int PAGE_BYTES    = 256,
   parameter bit RD_REGISTERED = 1'b0,
   localparam int PGW          = $clog2(NUM_PAGES) + 1,
   localparam int OFFW         = $clog2(PAGE_BYTES),
   localparam int MW           = PGW - 1 + OFFW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   output logic          irq,
   input  logic [MW-1:0] mem_raddr,
   output logic [7:0]    mem_rdata
);
   generate
      if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("NUM_PAGES must be a power of two, at least 2");
      end
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page_size
         $error("PAGE_BYTES must be a power of two, at least 2");
      end
      if (PGW > 7) begin : g_bad_width
         $error("page numbers must fit a byte register");
      end
   endgenerate

   logic           halt, lock, mem_we, pkt_done, abort;
   logic [PGW-1:0] first_pg, limit_pg, bound_pg, curr_pg, done_page;
   logic [MW-1:0]  mem_waddr;
   logic [7:0]     mem_wdata;

   rxr_regs #(.PGW(PGW), .RST_LIMIT(NUM_PAGES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .pkt_done(pkt_done), .done_page(done_page), .abort(abort),
      .halt(halt), .lock(lock), .first_pg(first_pg), .limit_pg(limit_pg),
      .bound_pg(bound_pg), .curr_pg(curr_pg), .irq(irq)
   );

   rxr_wrctl #(.PGW(PGW), .OFFW(OFFW), .MW(MW)) u_wrctl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .halt(halt), .lock(lock), .first_pg(first_pg),
      .limit_pg(limit_pg), .bound_pg(bound_pg), .curr_pg(curr_pg),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .pkt_done(pkt_done), .done_page(done_page), .abort(abort)
   );

   rxr_mem #(.MW(MW), .REG_RD(RD_REGISTERED)) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

   // R5
   ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> irq);
   // R9
   halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !mem_we);
endmodule

// File: tb/rx_page_ring_test.sv
module rx_page_ring_test;
   localparam int MW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0, rx_last = 1'b0, reg_wr = 1'b0;
   logic [7:0]    rx_data = '0, reg_wdata = '0;
   logic [2:0]    reg_addr = '0;
   logic [MW-1:0] mem_raddr = '0;
   logic [7:0]    reg_rdata, mem_rdata;
   logic          irq;

   int checks = 0, failures = 0;
   bit done_flag = 0;

   typedef struct {int a; int d; string req;} sb_item_t;
   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   rx_page_ring uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bnext(input int p);
      return (p + 1 == 6) ? 1 : p + 1;
   endfunction

   // scoreboard driver side: expected bytes of a packet stored from page pg
   task automatic push_pkt(input int pg, input int seed, input int len, input string req);
      int p = pg;
      for (int i = 0; i < len; i++) begin
         if (i != 0 && i % 256 == 0) p = bnext(p);
         sb_q.push_back('{a: p * 256 + i % 256, d: (seed + i) & 8'hFF, req: req});
      end
   endtask

   // scoreboard monitor: pops expected bytes and compares with the ring memory
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            mem_raddr = MW'(it.a);
            #1;
            chk(it.req, int'(mem_rdata), it.d);
         end
      end
   end

   task automatic wait_sb;
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic put_byte(input int d, input bit last);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(d); rx_last = last;
   endtask

   task automatic idle_in;
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic send_run(input int seed, input int from, input int upto, input bit last_at_end);
      for (int i = from; i < upto; i++)
         put_byte((seed + i) & 8'hFF, last_at_end && (i == upto - 1));
      idle_in();
   endtask

   task automatic reg_write(input logic [2:0] a, input int v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = 8'(v);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_check(input string req, input logic [2:0] a, input int exp);
      reg_addr = a;
      #1;
      chk(req, int'(reg_rdata), exp);
   endtask

   task automatic finish_up;
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      reg_check("R1 ctrl", 3'd0, 1);
      reg_check("R1 first", 3'd1, 0);
      reg_check("R1 limit", 3'd2, 8);
      reg_check("R1 bound", 3'd3, 7);
      reg_check("R1 curr", 3'd4, 0);
      reg_check("R1 status", 3'd5, 0);
      chk("R1 irq", int'(irq), 0);

      // R10 configure ring pages 1..5
      reg_write(3'd1, 1);
      reg_write(3'd2, 6);
      reg_write(3'd4, 1);
      reg_write(3'd3, 5);
      reg_write(3'd0, 0);
      reg_check("R10 first", 3'd1, 1);
      reg_check("R10 limit", 3'd2, 6);
      reg_check("R10 curr", 3'd4, 1);
      reg_check("R10 bound", 3'd3, 5);
      reg_check("R10 ctrl", 3'd0, 0);

      // R2 R3 short packet at page 1
      send_run(8'h10, 0, 10, 1);
      reg_check("R3 curr after A", 3'd4, 2);
      reg_check("R3 status done", 3'd5, 1);
      chk("R3 irq", int'(irq), 1);
      push_pkt(1, 8'h10, 10, "R2 pkt A");
      wait_sb();

      // R8 write-0 keeps, write-1 clears
      reg_write(3'd5, 0);
      reg_check("R8 write0 keeps", 3'd5, 1);
      reg_write(3'd5, 1);
      reg_check("R8 write1 clears", 3'd5, 0);
      chk("R8 irq low", int'(irq), 0);

      // R2 packet spanning pages 2 and 3
      send_run(8'h40, 0, 300, 1);
      reg_check("R2 curr after span", 3'd4, 4);
      push_pkt(2, 8'h40, 300, "R2 pkt B");
      wait_sb();
      reg_write(3'd5, 1);

      // R9 halt in the middle of a packet
      send_run(8'hA0, 0, 5, 0);
      reg_write(3'd0, 1);
      put_byte(8'hEE, 0);
      put_byte(8'hEE, 0);
      put_byte(8'hEE, 1);
      idle_in();
      reg_check("R9 curr held", 3'd4, 4);
      reg_check("R9 no status", 3'd5, 0);
      reg_write(3'd0, 0);
      send_run(8'hA0, 5, 10, 1);
      reg_check("R9 curr after resume", 3'd4, 5);
      push_pkt(4, 8'hA0, 10, "R9 pkt C");
      wait_sb();

      // R4 wrap from last ring page back to first
      reg_write(3'd3, 2);
      send_run(8'h60, 0, 20, 1);
      reg_check("R4 curr wrapped", 3'd4, 1);
      push_pkt(5, 8'h60, 20, "R4 pkt D");
      wait_sb();
      reg_write(3'd5, 1);

      // R5 long packet runs into boundary page 2
      send_run(8'h80, 0, 300, 1);
      reg_check("R5 curr kept", 3'd4, 1);
      reg_check("R5 overflow bit", 3'd5, 2);
      chk("R5 irq", int'(irq), 1);
      // R6 earlier packets intact
      push_pkt(2, 8'h40, 300, "R6 pkt B intact");
      push_pkt(5, 8'h60, 20, "R6 pkt D intact");
      wait_sb();

      // R7 boundary moved, reception stays suspended
      reg_write(3'd3, 4);
      send_run(8'h30, 0, 5, 1);
      reg_check("R7 curr unchanged", 3'd4, 1);
      reg_check("R7 no done", 3'd5, 2);
      reg_write(3'd5, 1);
      reg_check("R8 ovf survives done clear", 3'd5, 2);
      reg_write(3'd5, 2);
      reg_check("R8 ovf cleared", 3'd5, 0);
      send_run(8'h31, 0, 5, 1);
      reg_check("R7 still suspended", 3'd4, 1);

      // R7 halt cycle restores reception
      reg_write(3'd0, 1);
      reg_write(3'd0, 0);
      send_run(8'h30, 0, 5, 1);
      reg_check("R7 curr after recovery", 3'd4, 2);
      reg_check("R7 done after recovery", 3'd5, 1);
      push_pkt(1, 8'h30, 5, "R7 pkt G");
      wait_sb();

      finish_up();
   end
endmodule